// File: doc/BRIEF.md
# Dual Addressable Latch with Mode Decode

This block keeps two small storage banks of four bits each, driven by one shared set of controls: a 2-bit bit-select address, an active-low enable and an active-low clear. Each bank takes its own one-bit serial data input and shows its four stored bits as parallel outputs. Writing one bit at a time at chosen addresses turns a serial stream into a parallel word. Each bank can also work as a 1-of-4 demultiplexer, and all bits can be cleared together.

The design is fully synchronous. One rising clock edge samples every input, and the outputs are the registered bank contents. A mode therefore takes effect one clock after it is sampled. In the writing modes, an address change that flips more than one select bit between two consecutive samples could pick a bit that was never meant. The block flags such a change on a one-cycle fault output and drops that cycle's write.

Top module: `dual_addr_latch`

## Requirements
- R1: While the synchronous active-high `rst` is high at a rising edge, all outputs `q` become 0, `addr_fault` becomes 0 and the stored previous address becomes 0.
- R2: Clear mode (`en_n`=1, `clr_n`=0) makes all eight bits of `q` 0 one clock after it is sampled.
- R3: Demultiplex mode (`en_n`=0, `clr_n`=0) gives, one clock later, each bank a value in which only the addressed bit may be 1. That bit equals the bank's data input and every other bit is 0. The pattern stays stored when the mode ends.
- R4: Write mode (`en_n`=0, `clr_n`=1) loads the addressed bit of each bank with that bank's data input one clock later. The other three bits of each bank keep their values.
- R5: Hold mode (`en_n`=1, `clr_n`=1) leaves `q` unchanged, whatever `addr` and `din` are.
- R6: In write or demultiplex mode, if the sampled `addr` differs in more than one bit from the address sampled one clock earlier, `addr_fault` is 1 in the next cycle and `q` is left unchanged in that cycle. Otherwise `addr_fault` is 0.
- R7: The previous-address history is updated on every edge in every mode. An address change made in hold or clear mode therefore never raises a fault on the following write.
- R8: Bank 0 uses `din[0]` and drives `q[3:0]`; bank 1 uses `din[1]` and drives `q[7:4]`. Bit k of a bank is selected by `addr`=k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Active-low enable, shared by both banks |
| clr_n | input | 1 | Active-low clear, shared by both banks |
| addr | input | 2 | Bit-select address, shared by both banks |
| din | input | 2 | Serial data, one bit per bank |
| q | output | 8 | Stored bits, bank 1 in the upper nibble |
| addr_fault | output | 1 | One-cycle flag for a multi-bit address change in a writing mode |

## Verification
The assertions assume that every input is settled at the rising edge and that reset is held for at least one edge before any checked behaviour starts. They make no assumption about how the address moves, because multi-bit jumps are a legal input that the fault path must handle. The stimulus changes all inputs only at falling edges, and random address values often jump by two bits in every mode. This drives both the fault path and the history update during hold and clear.

// File: rtl/dual_addr_latch_pkg.sv
package dual_addr_latch_pkg;

    // Mode encoding is {en_n, clr_n}
    typedef enum logic [1:0] {
        MODE_DEMUX = 2'b00,
        MODE_WRITE = 2'b01,
        MODE_CLEAR = 2'b10,
        MODE_HOLD  = 2'b11
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  stall;   // write dropped due to address hazard
    } ctrl_t;

    function automatic mode_e decode_mode(input logic en_n, input logic clr_n);
        return mode_e'({en_n, clr_n});
    endfunction

    function automatic logic is_writing(input mode_e m);
        return (m == MODE_DEMUX) || (m == MODE_WRITE);
    endfunction

    function automatic int unsigned changed_bits(input logic [31:0] x);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 32; i++) n += int'(x[i]);
        return n;
    endfunction

endpackage

// File: rtl/dual_addr_latch_ctrl.sv
module dual_addr_latch_ctrl
    import dual_addr_latch_pkg::*;
#(
    parameter int ADDR_W = 2,
    localparam int BITS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_n,
    input  logic              clr_n,
    input  logic [ADDR_W-1:0] addr,
    output ctrl_t             ctrl,
    output logic [BITS-1:0]   sel,
    output logic              fault_q
);

    logic [ADDR_W-1:0] prev_addr;
    logic [31:0]       diff;
    mode_e             mode;
    logic              hazard;

    assign mode = decode_mode(en_n, clr_n);

    always_comb begin
        diff = '0;
        diff[ADDR_W-1:0] = prev_addr ^ addr;
    end

    assign hazard = is_writing(mode) && (changed_bits(diff) > 1);

    always_comb begin
        sel = '0;
        sel[addr] = 1'b1;
    end

    assign ctrl.mode  = mode;
    assign ctrl.stall = hazard;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_addr <= '0;
            fault_q   <= 1'b0;
        end else begin
            prev_addr <= addr;
            fault_q   <= hazard;
        end
    end

    AST_FAULT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        fault_q |-> is_writing($past(mode))) else $error("fault outside writing mode"); // R6

    AST_NO_FAULT_SAME_ADDR: assert property (@(posedge clk) disable iff (rst)
        (addr == prev_addr) |=> !fault_q) else $error("fault on unchanged address"); // R7

endmodule

// File: rtl/dual_addr_latch_bank.sv
module dual_addr_latch_bank
    import dual_addr_latch_pkg::*;
#(
    parameter int BITS = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  ctrl_t           ctrl,
    input  logic [BITS-1:0] sel,
    input  logic            d,
    output logic [BITS-1:0] q
);

    logic [BITS-1:0] q_nxt;
    logic [BITS-1:0] d_mask;

    assign d_mask = d ? sel : '0;

    always_comb begin
        q_nxt = q;
        unique case (ctrl.mode)
            MODE_CLEAR: q_nxt = '0;
            MODE_DEMUX: if (!ctrl.stall) q_nxt = d_mask;
            MODE_WRITE: if (!ctrl.stall) q_nxt = (q & ~sel) | d_mask;
            MODE_HOLD:  q_nxt = q;
            default:    q_nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_nxt;
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_CLEAR) |=> (q == '0)) else $error("clear left bits set"); // R2

    AST_DEMUX_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_DEMUX && !ctrl.stall) |=>
        ($onehot0(q) && ((q & ~$past(sel)) == '0))) else $error("demux pattern wrong"); // R3

    AST_WRITE_OTHERS: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_WRITE && !ctrl.stall) |=>
        ((q & ~$past(sel)) == ($past(q) & ~$past(sel)))) else $error("write touched other bits"); // R4

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_HOLD) |=> $stable(q)) else $error("hold changed bits"); // R5

    AST_STALL_KEEP: assert property (@(posedge clk) disable iff (rst)
        ctrl.stall |=> $stable(q)) else $error("stalled write changed bits"); // R6

endmodule

// File: rtl/dual_addr_latch.sv
module dual_addr_latch
    import dual_addr_latch_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 2,
    localparam int BITS     = 1 << ADDR_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en_n,
    input  logic                      clr_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NUM_BANKS-1:0]      din,
    output logic [NUM_BANKS*BITS-1:0] q,
    output logic                      addr_fault
);

    ctrl_t           ctrl;
    logic [BITS-1:0] sel;

    dual_addr_latch_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .en_n    (en_n),
        .clr_n   (clr_n),
        .addr    (addr),
        .ctrl    (ctrl),
        .sel     (sel),
        .fault_q (addr_fault)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        dual_addr_latch_bank #(.BITS(BITS)) u_bank (
            .clk  (clk),
            .rst  (rst),
            .ctrl (ctrl),
            .sel  (sel),
            .d    (din[b]),
            .q    (q[b*BITS +: BITS])
        );
    end

    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (q == '0 && !addr_fault)) else $error("reset left state"); // R1

endmodule

// File: tb/dual_addr_latch_test.sv
module dual_addr_latch_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       en_n, clr_n;
    logic [1:0] addr, din;
    logic [7:0] q;
    logic       addr_fault;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] m_q;
    logic [1:0] m_prev;
    logic       m_fault;

    always #10 clk = ~clk;

    dual_addr_latch uut (
        .clk(clk), .rst(rst), .en_n(en_n), .clr_n(clr_n),
        .addr(addr), .din(din), .q(q), .addr_fault(addr_fault)
    );

    function automatic logic [3:0] model_bank(input logic [3:0] cur, input logic e, input logic c,
                                              input logic [1:0] a, input logic d, input logic stall);
        logic [3:0] m;
        m = 4'b0001 << a;
        case ({e, c})
            2'b10: return 4'b0000;
            2'b00: return stall ? cur : (d ? m : 4'b0000);
            2'b01: return stall ? cur : ((cur & ~m) | (d ? m : 4'b0000));
            default: return cur;
        endcase
    endfunction

    function automatic logic model_hazard(input logic e, input logic c, input logic [1:0] pa, input logic [1:0] a);
        return (!e) && ((pa ^ a) == 2'b11);
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at falling edge, update model at rising edge, compare shortly after
    task automatic step(input logic e, input logic c, input logic [1:0] a, input logic [1:0] d,
                        input string tag);
        logic st;
        @(negedge clk);
        rst = 1'b0; en_n = e; clr_n = c; addr = a; din = d;
        @(posedge clk);
        st = model_hazard(e, c, m_prev, a);
        m_q[3:0] = model_bank(m_q[3:0], e, c, a, d[0], st);
        m_q[7:4] = model_bank(m_q[7:4], e, c, a, d[1], st);
        m_fault = st;
        m_prev = a;
        #2;
        check(tag, q, m_q);
        check({tag, " R6 fault"}, {7'd0, addr_fault}, {7'd0, m_fault});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        m_q = '0; m_prev = '0; m_fault = 1'b0;
        check("R1 reset q", q, 8'h00);
        check("R1 reset fault", {7'd0, addr_fault}, 8'h00);
    endtask

    initial begin
        #3_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        string tg;
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; en_n = 1'b1; clr_n = 1'b1; addr = '0; din = '0;
        m_q = '0; m_prev = '0; m_fault = 1'b0;
        repeat (2) @(posedge clk);
        do_reset();

        // R4/R8: serial load of distinct words per bank
        step(0, 1, 2'd0, 2'b01, "R4 R8 write a0");
        step(0, 1, 2'd1, 2'b10, "R4 R8 write a1");
        step(0, 1, 2'd3, 2'b11, "R4 R8 write a3");
        check("R8 word", q, 8'b1010_1001);
        // R5: hold ignores address and data
        step(1, 1, 2'd2, 2'b11, "R5 hold");
        step(1, 1, 2'd1, 2'b00, "R5 hold");
        check("R5 held word", q, 8'b1010_1001);
        // R7: two-bit change in hold, then write at the same address: no fault
        step(1, 1, 2'd2, 2'b00, "R7 hold move");
        step(0, 1, 2'd2, 2'b11, "R7 write no fault");
        check("R7 no fault", {7'd0, addr_fault}, 8'h00);
        // R6: two-bit jump while writing
        step(0, 1, 2'd1, 2'b00, "R6 jump 2->1");
        check("R6 fault seen", {7'd0, addr_fault}, 8'h01);
        check("R6 q kept", q, 8'b1110_1101);
        // R3: demux, then leave and keep pattern
        step(0, 0, 2'd1, 2'b11, "R3 demux");
        step(0, 0, 2'd0, 2'b01, "R3 demux");
        check("R3 pattern", q, 8'b0000_0001);
        step(1, 1, 2'd0, 2'b10, "R3 retained");
        check("R3 retained", q, 8'b0000_0001);
        // R2: clear
        step(1, 0, 2'd3, 2'b11, "R2 clear");
        check("R2 zero", q, 8'h00);
        // R1/R7: reset clears history, so write at 3 now faults
        step(0, 1, 2'd3, 2'b11, "R4 preload");
        do_reset();
        step(0, 1, 2'd3, 2'b11, "R7 history after reset");
        check("R7 fault after reset", {7'd0, addr_fault}, 8'h01);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] md;
            md = 2'($urandom_range(0, 3));
            case (md)
                2'b00: tg = "R3 rnd demux";
                2'b01: tg = "R4 rnd write";
                2'b10: tg = "R2 rnd clear";
                default: tg = "R5 rnd hold";
            endcase
            step(md[1], md[0], 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), tg);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule